// File: doc/BRIEF.md
# Command-Ring Consumer and Operand Sequencer

This block is the control half of a complex-vector multiply/accumulate engine. Commands sit in a ring held in storage outside the block. A producer advances the ring's head pointer. The block owns the tail pointer. When the ring is empty the block re-examines it only at a fixed polling interval. When the ring has an entry, the block reads the descriptor at the tail slot and advances the tail. It then walks the memory regions the command needs, one bus word per request. Every returned operand word is forwarded to the datapath, tagged with the region it came from.

After the operand reads, the block pulses a start to the arithmetic datapath and passes it the opcode, the reduce flag, an alias flag and the inner-loop trip count. It then waits for the datapath to report completion. Next it drains the datapath's result stream into the Y region, then signals completion for the command. A descriptor that carries the end opcode stops the consumer, and a later start resumes it.

Bus addresses are element addresses. One request moves one bus word that holds PF = MEM_BW / (2·ELEM_W) complex elements. The request for word k of a region therefore carries the region base plus k·PF. The descriptor dimensions are assumed to be non-zero. RING_DEPTH is assumed to be a power of two.

Top module: `vmac_cmd_sequencer`

## Requirements
- R1: Reset state. After reset, busy, stopped, cmd_done and mem_req_valid are 0, and ring_tail and cmd_count are 0.
- R2: Empty-ring polling. Start is accepted only while idle or stopped. The ring is first examined one cycle after start is sampled. When head equals tail no descriptor is taken. The ring is then examined again every POLL_CYCLES (64) cycles, so a dequeue edge falls exactly 1 + 64·k cycles after the start edge.
- R3: Dequeue. The descriptor on the cmd_* inputs is taken from slot ring_tail. The tail then advances by one, wrapping modulo RING_DEPTH.
- R4: The A region is read first. It takes ceil(rows·cols/PF) read requests at a_addr + k·PF, in increasing k. There is never more than one read outstanding, so mem_req_valid stays low from a read grant until its response.
- R5: The B region is read only for op 1 (inner product) and op 2 (sum), right after A and with the same count and address rule. When b_addr equals a_addr the B read is skipped and dp_alias is 1 at dp_start.
- R6: The alpha column is read only for op 0 (scalar multiply) with alpha_direct = 0. It takes ceil(rows/PF) requests at alpha_addr + k·PF, after A.
- R7: After the last operand response, dp_start is a one-cycle pulse. With it, dp_trips = rows·ceil(cols/PF), and dp_op and dp_reduce carry the descriptor's fields. The block then waits for dp_done.
- R8: The Y region is written after dp_done. It takes ceil(E/PF) write requests at y_addr + k·PF, where E = cols when reduce = 1 and E = rows·cols otherwise. The write data is res_data, a write is requested only while res_valid is 1, and res_ready equals mem_req_ready while writing.
- R9: After the last Y write, cmd_done pulses for one cycle and cmd_count rises by one. The next descriptor is examined only after that.
- R10: A descriptor with op 3 (end) causes no bus transfer and leaves cmd_count unchanged. The tail still advances, after which stopped is 1 and busy is 0.
- R11: Each read response is forwarded on opd_valid/opd_data in the response cycle, with opd_sel = 0 for A, 1 for B and 2 for alpha.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume consuming the ring |
| busy | output | 1 | Consumer running |
| stopped | output | 1 | Halted on an end opcode |
| ring_head | input | PTR_W | Producer's head pointer |
| ring_tail | output | PTR_W | Consumer's tail pointer, also the descriptor slot index |
| cmd_op | input | 2 | Descriptor opcode: 0 scalar, 1 inner, 2 sum, 3 end |
| cmd_rows | input | DIM_W | Row count |
| cmd_cols | input | DIM_W | Column count |
| cmd_a_addr | input | ADDR_W | A region element address |
| cmd_b_addr | input | ADDR_W | B region element address |
| cmd_y_addr | input | ADDR_W | Y region element address |
| cmd_alpha_addr | input | ADDR_W | Alpha column element address |
| cmd_alpha_direct | input | 1 | Alpha is an immediate (no memory read) |
| cmd_reduce | input | 1 | Column reduction enabled |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request grant |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Element address of the word |
| mem_req_wdata | output | MEM_BW | Write word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | MEM_BW | Read response word |
| opd_valid | output | 1 | Operand word valid |
| opd_sel | output | 2 | Operand source: 0 A, 1 B, 2 alpha |
| opd_data | output | MEM_BW | Operand word |
| dp_start | output | 1 | Datapath start pulse |
| dp_op | output | 2 | Opcode for the datapath |
| dp_reduce | output | 1 | Reduce flag for the datapath |
| dp_alias | output | 1 | B reuses the A data |
| dp_trips | output | 2·DIM_W | Inner-loop trip count |
| dp_done | input | 1 | Datapath finished |
| res_valid | input | 1 | Result word valid |
| res_ready | output | 1 | Result word accepted |
| res_data | input | MEM_BW | Result word |
| cmd_done | output | 1 | Command-complete pulse |
| cmd_count | output | CNT_W | Completed command count |

## Verification
The hardest situation to reach is a producer that publishes a command in the middle of a poll wait. The dequeue must then land on the next 64-cycle boundary, not when the head changes. The bench starts the consumer on an empty ring and moves the head 20 cycles later. It then requires the first tail step exactly 65 cycles after the start edge. Alias skipping, indirect alpha, reduction sizing and ring wrap-around each need a crafted descriptor: equal A and B addresses for inner product and for sum, both alpha modes, and a second run that starts at slot 7 and halts at slot 0. Irregular grants, response latencies of one or two cycles and gaps in the result stream exercise back-pressure throughout.

// File: rtl/vmac_seq_pkg.sv
package vmac_seq_pkg;

  localparam logic [1:0] OP_SCALE = 2'd0;
  localparam logic [1:0] OP_INNER = 2'd1;
  localparam logic [1:0] OP_SUM   = 2'd2;
  localparam logic [1:0] OP_END   = 2'd3;

  localparam logic [1:0] SRC_A  = 2'd0;
  localparam logic [1:0] SRC_B  = 2'd1;
  localparam logic [1:0] SRC_AL = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_POLL, ST_DISP,
    ST_RD_A, ST_RD_B, ST_RD_AL,
    ST_CALC_GO, ST_CALC_WAIT, ST_WR_Y, ST_FIN, ST_HALT
  } seq_state_e;

endpackage

// File: rtl/vmac_poll_timer.sv
module vmac_poll_timer #(
  parameter int POLL_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(POLL_CYCLES) + 1;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  // run is held for POLL_CYCLES-1 cycles; the re-check cycle completes the period
  assign expire = run && (cnt == TW'(POLL_CYCLES - 2));

  AST_POLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R2

endmodule

// File: rtl/vmac_region_walker.sv
module vmac_region_walker #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int PF     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_words,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= load_addr;
      remain <= load_words;
    end else if (step) begin
      addr   <= addr + ADDR_W'(PF);
      remain <= remain - 1'b1;
    end
  end

  assign last = (remain == LEN_W'(1));

  AST_WALK_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> (remain != '0)); // R4

endmodule

// File: rtl/vmac_cmd_decode.sv
module vmac_cmd_decode #(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8,
  parameter int PF     = 2
) (
  input  logic [1:0]         op,
  input  logic [DIM_W-1:0]   rows,
  input  logic [DIM_W-1:0]   cols,
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [ADDR_W-1:0]  b_addr,
  input  logic               alpha_direct,
  input  logic               reduce,
  output logic               read_b,
  output logic               alias_ab,
  output logic               read_alpha,
  output logic [2*DIM_W-1:0] a_words,
  output logic [2*DIM_W-1:0] alpha_words,
  output logic [2*DIM_W-1:0] y_words,
  output logic [2*DIM_W-1:0] trips
);
  import vmac_seq_pkg::*;

  localparam int LEN_W = 2 * DIM_W;
  localparam int WX    = LEN_W + 1;

  logic [LEN_W-1:0] elems;
  logic [LEN_W-1:0] y_elems;
  logic [LEN_W-1:0] col_words;
  logic             uses_b;

  assign elems   = LEN_W'(rows) * LEN_W'(cols);
  assign y_elems = reduce ? LEN_W'(cols) : elems;

  assign a_words     = LEN_W'((WX'(elems)   + WX'(PF - 1)) / WX'(PF));
  assign y_words     = LEN_W'((WX'(y_elems) + WX'(PF - 1)) / WX'(PF));
  assign alpha_words = LEN_W'((WX'(rows)    + WX'(PF - 1)) / WX'(PF));
  assign col_words   = LEN_W'((WX'(cols)    + WX'(PF - 1)) / WX'(PF));
  assign trips       = LEN_W'(rows) * col_words;

  assign uses_b     = (op == OP_INNER) || (op == OP_SUM);
  assign alias_ab   = uses_b && (a_addr == b_addr);
  assign read_b     = uses_b && !alias_ab;
  assign read_alpha = (op == OP_SCALE) && !alpha_direct;

endmodule

// File: rtl/vmac_cmd_sequencer.sv
module vmac_cmd_sequencer #(
  parameter int ADDR_W      = 16,
  parameter int DIM_W       = 8,
  parameter int MEM_BW      = 64,
  parameter int ELEM_W      = 16,
  parameter int RING_DEPTH  = 8,
  parameter int POLL_CYCLES = 64,
  parameter int CNT_W       = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        busy,
  output logic                        stopped,
  input  logic [$clog2(RING_DEPTH)-1:0] ring_head,
  output logic [$clog2(RING_DEPTH)-1:0] ring_tail,
  input  logic [1:0]                  cmd_op,
  input  logic [DIM_W-1:0]            cmd_rows,
  input  logic [DIM_W-1:0]            cmd_cols,
  input  logic [ADDR_W-1:0]           cmd_a_addr,
  input  logic [ADDR_W-1:0]           cmd_b_addr,
  input  logic [ADDR_W-1:0]           cmd_y_addr,
  input  logic [ADDR_W-1:0]           cmd_alpha_addr,
  input  logic                        cmd_alpha_direct,
  input  logic                        cmd_reduce,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic                        mem_req_write,
  output logic [ADDR_W-1:0]           mem_req_addr,
  output logic [MEM_BW-1:0]           mem_req_wdata,
  input  logic                        mem_rsp_valid,
  input  logic [MEM_BW-1:0]           mem_rsp_rdata,
  output logic                        opd_valid,
  output logic [1:0]                  opd_sel,
  output logic [MEM_BW-1:0]           opd_data,
  output logic                        dp_start,
  output logic [1:0]                  dp_op,
  output logic                        dp_reduce,
  output logic                        dp_alias,
  output logic [2*DIM_W-1:0]          dp_trips,
  input  logic                        dp_done,
  input  logic                        res_valid,
  output logic                        res_ready,
  input  logic [MEM_BW-1:0]           res_data,
  output logic                        cmd_done,
  output logic [CNT_W-1:0]            cmd_count
);
  import vmac_seq_pkg::*;

  localparam int PF    = MEM_BW / (2 * ELEM_W);
  localparam int PTR_W = $clog2(RING_DEPTH);
  localparam int LEN_W = 2 * DIM_W;

  seq_state_e state, nxt;

  // captured descriptor
  logic [1:0]        c_op;
  logic [DIM_W-1:0]  c_rows, c_cols;
  logic [ADDR_W-1:0] c_a, c_b, c_y, c_al;
  logic              c_direct, c_reduce;

  logic [PTR_W-1:0]  tail;
  logic              waiting;
  logic [CNT_W-1:0]  done_cnt;

  logic              read_b, alias_ab, read_alpha;
  logic [LEN_W-1:0]  a_words, alpha_words, y_words, trips;

  logic              poll_expire;
  logic              walk_load, walk_step, walk_last;
  logic [ADDR_W-1:0] walk_addr, load_addr;
  logic [LEN_W-1:0]  load_words;

  logic              ring_empty, rd_phase, rd_grant, rsp_take, wr_take;

  vmac_cmd_decode #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PF(PF)) u_decode (
    .op(c_op), .rows(c_rows), .cols(c_cols), .a_addr(c_a), .b_addr(c_b),
    .alpha_direct(c_direct), .reduce(c_reduce),
    .read_b(read_b), .alias_ab(alias_ab), .read_alpha(read_alpha),
    .a_words(a_words), .alpha_words(alpha_words), .y_words(y_words), .trips(trips)
  );

  vmac_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk(clk), .rst_n(rst_n), .run(state == ST_POLL), .expire(poll_expire)
  );

  vmac_region_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PF(PF)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(walk_load), .load_addr(load_addr),
    .load_words(load_words), .step(walk_step), .addr(walk_addr), .last(walk_last)
  );

  assign ring_empty = (ring_head == tail);
  assign rd_phase   = (state == ST_RD_A) || (state == ST_RD_B) || (state == ST_RD_AL);
  assign rd_grant   = rd_phase && !waiting && mem_req_ready;
  assign rsp_take   = rd_phase && waiting && mem_rsp_valid;
  assign wr_take    = (state == ST_WR_Y) && res_valid && mem_req_ready;
  assign walk_step  = rsp_take || wr_take;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE, ST_HALT: if (start) nxt = ST_CHECK;
      ST_CHECK:     nxt = ring_empty ? ST_POLL : ST_DISP;
      ST_POLL:      if (poll_expire) nxt = ST_CHECK;
      ST_DISP:      nxt = (c_op == OP_END) ? ST_HALT : ST_RD_A;
      ST_RD_A:      if (rsp_take && walk_last)
                      nxt = read_b ? ST_RD_B : (read_alpha ? ST_RD_AL : ST_CALC_GO);
      ST_RD_B:      if (rsp_take && walk_last)
                      nxt = read_alpha ? ST_RD_AL : ST_CALC_GO;
      ST_RD_AL:     if (rsp_take && walk_last) nxt = ST_CALC_GO;
      ST_CALC_GO:   nxt = ST_CALC_WAIT;
      ST_CALC_WAIT: if (dp_done) nxt = ST_WR_Y;
      ST_WR_Y:      if (wr_take && walk_last) nxt = ST_FIN;
      ST_FIN:       nxt = ST_CHECK;
      default:      nxt = ST_IDLE;
    endcase
  end

  // region walker is reloaded on every entry into a transfer phase
  always_comb begin
    walk_load  = 1'b0;
    load_addr  = c_a;
    load_words = a_words;
    if (nxt != state) begin
      unique case (nxt)
        ST_RD_A:  begin walk_load = 1'b1; load_addr = c_a;  load_words = a_words;     end
        ST_RD_B:  begin walk_load = 1'b1; load_addr = c_b;  load_words = a_words;     end
        ST_RD_AL: begin walk_load = 1'b1; load_addr = c_al; load_words = alpha_words; end
        ST_WR_Y:  begin walk_load = 1'b1; load_addr = c_y;  load_words = y_words;     end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tail     <= '0;
      waiting  <= 1'b0;
      done_cnt <= '0;
      c_op     <= OP_END;
      c_rows   <= '0;
      c_cols   <= '0;
      c_a      <= '0;
      c_b      <= '0;
      c_y      <= '0;
      c_al     <= '0;
      c_direct <= 1'b0;
      c_reduce <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_CHECK && !ring_empty) begin
        tail     <= tail + 1'b1;
        c_op     <= cmd_op;
        c_rows   <= cmd_rows;
        c_cols   <= cmd_cols;
        c_a      <= cmd_a_addr;
        c_b      <= cmd_b_addr;
        c_y      <= cmd_y_addr;
        c_al     <= cmd_alpha_addr;
        c_direct <= cmd_alpha_direct;
        c_reduce <= cmd_reduce;
      end
      if (rd_grant)      waiting <= 1'b1;
      else if (rsp_take) waiting <= 1'b0;
      if (state == ST_FIN) done_cnt <= done_cnt + 1'b1;
    end
  end

  assign busy      = (state != ST_IDLE) && (state != ST_HALT);
  assign stopped   = (state == ST_HALT);
  assign ring_tail = tail;
  assign cmd_done  = (state == ST_FIN);
  assign cmd_count = done_cnt;

  assign mem_req_valid = (rd_phase && !waiting) || ((state == ST_WR_Y) && res_valid);
  assign mem_req_write = (state == ST_WR_Y);
  assign mem_req_addr  = walk_addr;
  assign mem_req_wdata = res_data;
  assign res_ready     = (state == ST_WR_Y) && mem_req_ready;

  assign opd_valid = rsp_take;
  assign opd_data  = mem_rsp_rdata;
  assign opd_sel   = (state == ST_RD_B) ? SRC_B : ((state == ST_RD_AL) ? SRC_AL : SRC_A);

  assign dp_start  = (state == ST_CALC_GO);
  assign dp_op     = c_op;
  assign dp_reduce = c_reduce;
  assign dp_alias  = alias_ab;
  assign dp_trips  = trips;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_write) |=> !mem_req_valid); // R4
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_head == ring_tail) |=> $stable(ring_tail)); // R2
  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(ring_tail) || ring_tail == PTR_W'($past(ring_tail) + 1'b1))); // R3
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!mem_req_valid && !busy)); // R10
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (cmd_count == CNT_W'($past(cmd_count) + 1'b1))); // R9
  AST_WRITE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> res_valid); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |=> !dp_start); // R7

endmodule

// File: tb/sim_vmac_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_vmac_cmd_sequencer;
  localparam int ADDR_W = 16, DIM_W = 8, MEM_BW = 64, ELEM_W = 16;
  localparam int DEPTH = 8, POLL = 64, CNT_W = 16;
  localparam int PF = MEM_BW / (2 * ELEM_W);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, stopped, cmd_done;
  logic [2:0] ring_head = '0, ring_tail;
  logic [1:0] cmd_op;
  logic [DIM_W-1:0] cmd_rows, cmd_cols;
  logic [ADDR_W-1:0] cmd_a_addr, cmd_b_addr, cmd_y_addr, cmd_alpha_addr;
  logic cmd_alpha_direct, cmd_reduce;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [MEM_BW-1:0] mem_req_wdata, mem_rsp_rdata = '0, opd_data, res_data = '0;
  logic mem_rsp_valid = 1'b0, opd_valid, dp_start, dp_reduce, dp_alias;
  logic dp_done = 1'b0, res_valid = 1'b0, res_ready;
  logic [1:0] opd_sel, dp_op;
  logic [2*DIM_W-1:0] dp_trips;
  logic [CNT_W-1:0] cmd_count;

  always #4 clk = ~clk;

  // ring storage, indexed by slot
  int s_op[DEPTH], s_rows[DEPTH], s_cols[DEPTH], s_a[DEPTH], s_b[DEPTH];
  int s_y[DEPTH], s_al[DEPTH], s_dir[DEPTH], s_red[DEPTH];

  assign cmd_op           = 2'(s_op[ring_tail]);
  assign cmd_rows         = DIM_W'(s_rows[ring_tail]);
  assign cmd_cols         = DIM_W'(s_cols[ring_tail]);
  assign cmd_a_addr       = ADDR_W'(s_a[ring_tail]);
  assign cmd_b_addr       = ADDR_W'(s_b[ring_tail]);
  assign cmd_y_addr       = ADDR_W'(s_y[ring_tail]);
  assign cmd_alpha_addr   = ADDR_W'(s_al[ring_tail]);
  assign cmd_alpha_direct = s_dir[ring_tail] != 0;
  assign cmd_reduce       = s_red[ring_tail] != 0;

  vmac_cmd_sequencer u0 (.*);

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model state
  int q_w[$], q_addr[$], q_sel[$];
  int cur_op, cur_red, cur_alias, cur_trips, cur_yw;
  int y_pend = 0, rsp_cnt = 0, rsp_sel = 0, dp_cnt = 0, hs_n = 0;
  int done_seen = 0, deq_seen = 0, prev_tail = 0;
  int start_cyc = 0, first_deq = 0;
  longint rsp_word = 0;

  function automatic int cdiv(int x); return (x + PF - 1) / PF; endfunction

  task automatic push_region(int w, int base, int words, int sel);
    for (int k = 0; k < words; k++) begin
      q_w.push_back(w); q_addr.push_back((base + k * PF) & 16'hFFFF); q_sel.push_back(sel);
    end
  endtask

  task automatic on_dequeue(int s);
    int need_b, ali;
    if (first_deq != 0) begin
      chk(cyc == first_deq, "R2", "dequeue cycle after start", cyc, first_deq);
      first_deq = 0;
    end
    chk(q_w.size() == 0 && y_pend == 0, "R9", "dequeue before previous done", q_w.size(), 0);
    deq_seen++;
    if (s_op[s] == 3) return;
    need_b = (s_op[s] == 1 || s_op[s] == 2);
    ali    = need_b && (s_a[s] == s_b[s]);
    push_region(0, s_a[s], cdiv(s_rows[s] * s_cols[s]), 0);                  // R4
    if (need_b && !ali) push_region(0, s_b[s], cdiv(s_rows[s] * s_cols[s]), 1); // R5
    if (s_op[s] == 0 && s_dir[s] == 0) push_region(0, s_al[s], cdiv(s_rows[s]), 2); // R6
    cur_yw = cdiv(s_red[s] != 0 ? s_cols[s] : s_rows[s] * s_cols[s]);
    push_region(1, s_y[s], cur_yw, 0);                                        // R8
    cur_op = s_op[s]; cur_red = s_red[s]; cur_alias = ali;
    cur_trips = s_rows[s] * cdiv(s_cols[s]);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      // drive environment
      mem_req_ready = (cyc % 5) != 2;
      mem_rsp_valid = 1'b0;
      if (rsp_cnt == 1) begin
        mem_rsp_valid = 1'b1; mem_rsp_rdata = MEM_BW'(rsp_word); rsp_cnt = 0;
      end else if (rsp_cnt > 1) rsp_cnt--;
      dp_done = 1'b0;
      if (dp_cnt == 1) begin dp_done = 1'b1; dp_cnt = 0; y_pend = cur_yw; end
      else if (dp_cnt > 1) dp_cnt--;
      res_valid = (y_pend > 0) && (cyc % 7 != 3);
      res_data  = MEM_BW'(64'hC0DE_0000_0000_0000 + longint'(y_pend));
      #1;
      // R11 operand forwarding
      if (mem_rsp_valid) begin
        chk(opd_valid == 1'b1, "R11", "opd_valid on response", opd_valid, 1);
        chk(opd_sel == 2'(rsp_sel), "R11", "opd_sel", opd_sel, rsp_sel);
        chk(opd_data == mem_rsp_rdata, "R11", "opd_data", opd_data, mem_rsp_rdata);
      end else
        chk(opd_valid == 1'b0, "R11", "opd_valid without response", opd_valid, 0);
      // bus handshakes against the expected transfer list
      if (mem_req_valid && mem_req_ready) begin
        if (q_w.size() == 0) chk(0, "R10", "unexpected bus transfer", mem_req_addr, -1);
        else begin
          chk(int'(mem_req_write) == q_w[0], "R4", "request direction", mem_req_write, q_w[0]);
          chk(int'(mem_req_addr) == q_addr[0], q_w[0] ? "R8" : "R4", "request address",
              mem_req_addr, q_addr[0]);
          if (mem_req_write) begin
            chk(mem_req_wdata == res_data && res_ready, "R8", "write data/res_ready",
                mem_req_wdata, res_data);
            y_pend--;
          end else begin
            rsp_sel  = q_sel[0];
            rsp_cnt  = 1 + (hs_n % 2);
            rsp_word = 64'h5A00_0000_0000_0000 + longint'(mem_req_addr) + (longint'(hs_n) << 20);
          end
          hs_n++;
          void'(q_w.pop_front()); void'(q_addr.pop_front()); void'(q_sel.pop_front());
        end
      end
      if (mem_req_valid && !mem_req_write)
        chk(rsp_cnt == 0 || (mem_req_ready && rsp_cnt != 0), "R4", "read while outstanding", rsp_cnt, 0);
      if (mem_req_write) chk(res_ready == mem_req_ready, "R8", "res_ready mirrors grant", res_ready, mem_req_ready);
      // R7 datapath start
      if (dp_start) begin
        chk(q_w.size() > 0 && q_w[0] == 1, "R7", "start before reads done", q_w.size(), 0);
        chk(int'(dp_trips) == cur_trips, "R7", "dp_trips", dp_trips, cur_trips);
        chk(int'(dp_alias) == cur_alias, "R5", "dp_alias", dp_alias, cur_alias);
        chk(int'(dp_op) == cur_op && int'(dp_reduce) == cur_red, "R7", "dp_op/reduce", dp_op, cur_op);
        dp_cnt = 3;
      end
      // R9 completion
      if (cmd_done) begin
        chk(q_w.size() == 0 && int'(cmd_count) == done_seen, "R9", "cmd_count at done",
            cmd_count, done_seen);
        done_seen++;
      end
      // R3 dequeue
      if (int'(ring_tail) != prev_tail) begin
        chk(int'(ring_tail) == ((prev_tail + 1) % DEPTH), "R3", "tail step", ring_tail, (prev_tail + 1) % DEPTH);
        on_dequeue(prev_tail);
        prev_tail = int'(ring_tail);
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1; start_cyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_stopped();
    for (int i = 0; i < 4000 && !stopped; i++) @(negedge clk);
    #2;
  endtask

  task automatic set_slot(int s, int op, int r, int c, int a, int b, int y, int al, int d, int red);
    s_op[s] = op; s_rows[s] = r; s_cols[s] = c; s_a[s] = a; s_b[s] = b;
    s_y[s] = y; s_al[s] = al; s_dir[s] = d; s_red[s] = red;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) set_slot(i, 3, 1, 1, 0, 0, 0, 0, 1, 0);
    set_slot(0, 1, 2, 3, 100, 200, 300, 0, 1, 0); // inner product, distinct B
    set_slot(1, 1, 1, 4, 40, 40, 400, 0, 1, 1);   // inner product, B aliases A, reduce
    set_slot(2, 2, 3, 1, 10, 20, 500, 0, 1, 1);   // sum, reduce to one column
    set_slot(3, 0, 2, 2, 50, 0, 600, 60, 1, 0);   // scalar, direct alpha
    set_slot(4, 0, 3, 2, 70, 0, 700, 90, 0, 0);   // scalar, indirect alpha
    set_slot(5, 2, 1, 1, 5, 5, 800, 0, 1, 0);     // sum, B aliases A
    set_slot(6, 3, 1, 1, 0, 0, 0, 0, 1, 0);       // end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!busy && !stopped && !cmd_done && !mem_req_valid, "R1", "reset outputs", busy, 0);
    chk(ring_tail == 0 && cmd_count == 0, "R1", "reset tail/count", cmd_count, 0);

    // empty ring at start; producer publishes mid-poll
    pulse_start();
    first_deq = start_cyc + 1 + POLL;
    while (cyc < start_cyc + 20) @(negedge clk);
    chk(ring_tail == 0 && busy, "R2", "no dequeue on empty ring", ring_tail, 0);
    ring_head = 3'd7;
    wait_stopped();
    chk(stopped && !busy, "R10", "stopped after end", stopped, 1);
    chk(cmd_count == 6, "R10", "count excludes end", cmd_count, 6);
    chk(ring_tail == 7 && q_w.size() == 0, "R10", "tail past end, no pending transfer", ring_tail, 7);
    repeat (10) @(negedge clk);
    chk(stopped && ring_tail == 7, "R10", "stays halted", ring_tail, 7);

    // second run wraps the ring and starts on a non-empty ring
    set_slot(7, 1, 2, 2, 120, 130, 140, 0, 1, 0);
    set_slot(0, 3, 1, 1, 0, 0, 0, 0, 1, 0);
    ring_head = 3'd1;
    pulse_start();
    first_deq = start_cyc + 1;
    @(negedge clk); #2;
    chk(!stopped && busy, "R2", "restart from halt", busy, 1);
    wait_stopped();
    chk(stopped && cmd_count == 7, "R9", "count after wrap run", cmd_count, 7);
    chk(ring_tail == 1 && deq_seen == 9, "R3", "tail wrapped", ring_tail, 1);
    chk(done_seen == 7 && q_w.size() == 0, "R9", "done pulses", done_seen, 7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule